// File: doc/BRIEF.md
# System Bus Clock Divider Set

This block turns one fast source clock into three slower related rates: a core rate, a bus rate and a peripheral rate. All logic runs on the single input clock `clk`. Each derived rate comes out as a one-cycle clock-enable pulse per output period, together with a registered level that approximates the matching square wave. A 32-bit configuration word, captured on a load strobe, selects the divisor of each output through a fixed lookup table. It also selects whether the dividers count every `clk` cycle (PLL in use) or only the cycles on which `xtal_tick` is high (crystal rate, PLL bypassed).

The core and bus dividers count source ticks. The peripheral divider counts bus-enable pulses, so its period is the product of the bus and peripheral divisors. A new divisor is adopted only at the end of the period in progress, so no output period is ever cut short. Odd divisors give a level that is high for one input tick less than it is low.

Top module: `sysclk_divider_set`

## Requirements
- R1: The core divisor comes from word bits 27:25. Codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16. Codes 5, 6 and 7 give 1.
- R2: The bus divisor comes from word bits 22:20. Codes 0 to 7 give 1, 2, 4, 5, 6, 8, 16 and 32.
- R3: The peripheral divisor comes from word bits 19:18, where codes 0 to 3 give 1, 2, 4 and 8. It counts `bus_ce` pulses, so its period is the bus period times this divisor.
- R4: When word bit 23 is 1, every `clk` cycle is a source tick. When bit 23 is 0, only cycles with `xtal_tick` high are source ticks.
- R5: The word on `cfg_in` is captured only in a cycle with `cfg_load` high. Changes to `cfg_in` at any other time have no effect on the outputs.
- R6: A newly loaded divisor takes effect only at the end of the output period in progress. That period completes with the old length.
- R7: With a divisor of 1, the clock-enable pulses on every input tick and the level output stays high.
- R8: For a divisor d ≥ 2, the level is high for floor(d/2) input ticks of each period and low for the rest. For an odd d, the high phase is one input tick shorter than the low phase.
- R9: Reset (`rst` high at a clock edge, synchronous) clears the stored word to all zeros, which selects the crystal source and a divisor of 1 on all three outputs. During reset every `*_ce` is 0 and every `*_lvl` is 1.
- R10: A `*_ce` pulse lasts one cycle and appears in the cycle after the input tick that ends a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock (PLL rate) |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | Crystal-rate enable, used as the source when bit 23 is 0 |
| cfg_in | input | 32 | Configuration word |
| cfg_load | input | 1 | Capture strobe for `cfg_in` |
| core_ce | output | 1 | Core clock-enable pulse |
| core_lvl | output | 1 | Core clock level |
| bus_ce | output | 1 | Bus clock-enable pulse |
| bus_lvl | output | 1 | Bus clock level |
| per_ce | output | 1 | Peripheral clock-enable pulse |
| per_lvl | output | 1 | Peripheral clock level |

## Verification
A configuration load can land in the same cycle range as a running period of a different length. The bench provokes this by loading a word one cycle after a core pulse, while a divide-by-8 period is in progress. It then requires the interval up to the next pulse to still be 8 cycles, and the interval after that to be the new length of 2. The second collision is between the peripheral divider's tick and the bus boundary, since the peripheral counts bus pulses. Cascaded periods and level widths (for example 5×2 and 6×8) are measured by a scoreboard monitor that pops one expected period and high-time per output and compares them against what the ports show.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;
  localparam int NUM_OUT  = 3;
  localparam int CORE_IDX = 0;
  localparam int BUS_IDX  = 1;
  localparam int PER_IDX  = 2;

  // field positions in the configuration word
  localparam int CORE_LSB = 25;
  localparam int PLL_BIT  = 23;
  localparam int BUS_LSB  = 20;
  localparam int PER_LSB  = 18;

  function automatic int core_div(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int bus_div(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 8;
      3'd6: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int per_div(input logic [1:0] code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/sysdiv_decode.sv
module sysdiv_decode
  import sysdiv_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 6
) (
  input  logic [CFG_W-1:0]              cfg,
  output logic [NUM_OUT-1:0][DIV_W-1:0] div_o,
  output logic                          pll_sel
);
  logic cfg_unused;
  assign cfg_unused = ^{cfg[CFG_W-1:CORE_LSB+3], cfg[PLL_BIT+1], cfg[PER_LSB-1:0]};

  always_comb begin
    div_o[CORE_IDX] = DIV_W'(core_div(cfg[CORE_LSB +: 3]));
    div_o[BUS_IDX]  = DIV_W'(bus_div(cfg[BUS_LSB +: 3]));
    div_o[PER_IDX]  = DIV_W'(per_div(cfg[PER_LSB +: 2]));
    pll_sel         = cfg[PLL_BIT];
  end
endmodule

// File: rtl/sysdiv_stage.sv
module sysdiv_stage #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic [DIV_W-1:0] div_pend,
  output logic             ce_out,
  output logic             lvl_out
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt, div_cur, cnt_nxt, div_nxt;
  logic             at_end, lvl_nxt;

  always_comb begin
    at_end  = (cnt == div_cur - ONE);
    cnt_nxt = cnt;
    div_nxt = div_cur;
    if (tick_in) begin
      if (at_end) begin
        cnt_nxt = '0;
        div_nxt = div_pend;   // adopt new divisor only at boundary
      end else begin
        cnt_nxt = cnt + ONE;
      end
    end
    lvl_nxt = (div_nxt == ONE) ? 1'b1 : (cnt_nxt < (div_nxt >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      div_cur <= ONE;
      ce_out  <= 1'b0;
      lvl_out <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      div_cur <= div_nxt;
      ce_out  <= tick_in && at_end;
      lvl_out <= lvl_nxt;
    end
  end

  AST_CE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    ce_out |-> $past(tick_in)); // R10

  AST_DIV_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !(tick_in && at_end) |=> $stable(div_cur)); // R6

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < div_cur); // R8

  AST_DIV1_EVERY_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick_in && div_cur == ONE) |=> (ce_out && lvl_out)); // R7

  AST_PEND_NONZERO: assert property (@(posedge clk) disable iff (rst)
    div_pend != '0); // R2
endmodule

// File: rtl/sysclk_divider_set.sv
module sysclk_divider_set
  import sysdiv_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_tick,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             cfg_load,
  output logic             core_ce,
  output logic             core_lvl,
  output logic             bus_ce,
  output logic             bus_lvl,
  output logic             per_ce,
  output logic             per_lvl
);
  logic [CFG_W-1:0]              cfg_q;
  logic [NUM_OUT-1:0][DIV_W-1:0] div_pend;
  logic                          pll_sel, src_tick;
  logic [NUM_OUT-1:0]            stage_ce, stage_lvl;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_in;
  end

  sysdiv_decode #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_dec (
    .cfg     (cfg_q),
    .div_o   (div_pend),
    .pll_sel (pll_sel)
  );

  assign src_tick = pll_sel | xtal_tick;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_stage
    logic tick;
    if (i == PER_IDX) begin : g_cascade
      assign tick = stage_ce[BUS_IDX];
    end else begin : g_direct
      assign tick = src_tick;
    end
    sysdiv_stage #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .tick_in  (tick),
      .div_pend (div_pend[i]),
      .ce_out   (stage_ce[i]),
      .lvl_out  (stage_lvl[i])
    );
  end

  assign core_ce  = stage_ce[CORE_IDX];
  assign core_lvl = stage_lvl[CORE_IDX];
  assign bus_ce   = stage_ce[BUS_IDX];
  assign bus_lvl  = stage_lvl[BUS_IDX];
  assign per_ce   = stage_ce[PER_IDX];
  assign per_lvl  = stage_lvl[PER_IDX];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_q)); // R5

  AST_PER_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    per_ce |-> $past(bus_ce)); // R3

  AST_XTAL_PACE: assert property (@(posedge clk) disable iff (rst)
    (core_ce && !$past(pll_sel)) |-> $past(xtal_tick)); // R4
endmodule

// File: tb/sim_sysclk_divider_set.sv
module sim_sysclk_divider_set;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xtal_tick = 1'b0;
  logic [31:0] cfg_in = '0;
  logic        cfg_load = 1'b0;
  logic        core_ce, core_lvl, bus_ce, bus_lvl, per_ce, per_lvl;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    int    sel;
    int    per;
    int    hi;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  sysclk_divider_set u0 (
    .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .cfg_in(cfg_in), .cfg_load(cfg_load),
    .core_ce(core_ce), .core_lvl(core_lvl), .bus_ce(bus_ce), .bus_lvl(bus_lvl),
    .per_ce(per_ce), .per_lvl(per_lvl)
  );

  function automatic logic get_ce(int s);
    case (s)
      0: return core_ce;
      1: return bus_ce;
      default: return per_ce;
    endcase
  endfunction

  function automatic logic get_lvl(int s);
    case (s)
      0: return core_lvl;
      1: return bus_lvl;
      default: return per_lvl;
    endcase
  endfunction

  function automatic logic [31:0] mk(int pll, int c, int b, int p);
    return (32'(pll) << 23) | (32'(c) << 25) | (32'(b) << 20) | (32'(p) << 18);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // crystal enable: one cycle in three
  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      xtal_tick = (k == 2);
      k = (k == 2) ? 0 : k + 1;
    end
  end

  // scoreboard monitor
  initial begin
    exp_t it;
    int   p, h;
    forever begin
      while (q.size() == 0) @(negedge clk);
      it = q[0];
      do @(negedge clk); while (!get_ce(it.sel));
      p = 0;
      h = 0;
      do begin
        if (get_lvl(it.sel)) h++;
        p++;
        @(negedge clk);
      end while (!get_ce(it.sel));
      check(p == it.per, it.tag, $sformatf("out%0d period", it.sel), p, it.per);
      check(h == it.hi, it.tag, $sformatf("out%0d high", it.sel), h, it.hi);
      void'(q.pop_front());
    end
  end

  task automatic wait_ce(int s, int n);
    repeat (n) begin
      do @(negedge clk); while (!get_ce(s));
    end
  endtask

  task automatic expect3(int cp, int ch, int bp, int bh, int pp, int ph, string tag);
    exp_t e;
    e.tag = tag;
    e.sel = 0; e.per = cp; e.hi = ch; q.push_back(e);
    e.sel = 1; e.per = bp; e.hi = bh; q.push_back(e);
    e.sel = 2; e.per = pp; e.hi = ph; q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic load(logic [31:0] w);
    @(negedge clk);
    cfg_in   = w;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wait_ce(2, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int p;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(core_ce == 1'b0, "R9", "core_ce", int'(core_ce), 0);
    check(bus_ce == 1'b0, "R9", "bus_ce", int'(bus_ce), 0);
    check(per_ce == 1'b0, "R9", "per_ce", int'(per_ce), 0);
    check(core_lvl == 1'b1, "R9", "core_lvl", int'(core_lvl), 1);
    check(bus_lvl == 1'b1, "R9", "bus_lvl", int'(bus_lvl), 1);
    check(per_lvl == 1'b1, "R9", "per_lvl", int'(per_lvl), 1);
    rst = 1'b0;
    expect3(3, 3, 3, 3, 3, 3, "R9 R4 R7 defaults on crystal");

    load(mk(1, 2, 3, 1));
    expect3(4, 2, 5, 2, 10, 5, "R1 R2 R3 R8 4/5/5x2");
    load(mk(1, 4, 4, 3));
    expect3(16, 8, 6, 3, 48, 24, "R1 R2 R3 R8 16/6/6x8");
    load(mk(1, 6, 7, 2));
    expect3(1, 1, 32, 16, 128, 64, "R1 R2 R3 R7 fallback/32/32x4");
    load(mk(1, 7, 5, 0));
    expect3(1, 1, 8, 4, 8, 8, "R1 R2 R7 fallback/8/8x1");
    load(mk(1, 5, 6, 0));
    expect3(1, 1, 16, 8, 16, 16, "R1 R2 R7 fallback/16/16x1");
    load(mk(1, 0, 0, 0));
    expect3(1, 1, 1, 1, 1, 1, "R7 R10 all divide-by-1");
    load(mk(1, 1, 2, 0));
    expect3(2, 1, 4, 2, 4, 4, "R1 R2 R8 2/4/4x1");
    load(mk(0, 1, 3, 0));
    expect3(6, 3, 15, 6, 15, 15, "R4 R8 crystal 2/5/5x1");

    // R5: word changes without a strobe are ignored
    @(negedge clk);
    cfg_in = mk(1, 0, 0, 0);
    repeat (20) @(negedge clk);
    expect3(6, 3, 15, 6, 15, 15, "R5 no strobe");

    // R6: load during a divide-by-8 period
    load(mk(1, 3, 1, 0));
    wait_ce(0, 1);
    cfg_in   = mk(1, 1, 1, 0);
    cfg_load = 1'b1;
    fork
      begin
        @(negedge clk);
        cfg_load = 1'b0;
      end
    join_none
    p = 0;
    do begin p++; @(negedge clk); end while (!core_ce);
    check(p == 8, "R6", "period in progress", p, 8);
    p = 0;
    do begin p++; @(negedge clk); end while (!core_ce);
    check(p == 2, "R6", "first new period", p, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule